// File: doc/BRIEF.md
# Card Bus Clock Controller

This block derives the clock that drives a memory-card bus from a faster host clock. A 16-bit configuration word sets the divide ratio, turns the card clock on and off, lets the clock sleep while the bus has nothing to do, and pauses it whenever the data FIFO can neither take nor give a word. The same word also carries the launch-edge choice for outgoing command and data bits, the input-latch source select, and a bus-width field. That width field is decoded here and passed to the data path.

The configuration word is written through a single-cycle strobe and passes through a short delay pipe before it is used. The clock itself comes from a three-state phase sequencer. `CK_HIGH` counts the high half-period. `CK_LOW` counts the low half-period. `CK_PARK` holds the output low while the clock is not allowed to run. The named transitions are:

- `hi_done`: `CK_HIGH` to `CK_LOW` when the high count expires.
- `lo_go`: `CK_LOW` to `CK_HIGH` when the low count expires and running is allowed.
- `lo_stall`: `CK_LOW` to `CK_PARK` when the low count expires and running is not allowed.
- `park_go`: `CK_PARK` to `CK_HIGH` once running is allowed again.

Both `lo_go` and `park_go` load the divide value that will be used for the next full period. Every gating decision is taken only while the output is low. As a result, a high half-period is never cut short.

Top module: `cardclk_ctrl`

## Requirements
- R1: After reset, `card_clk_o` is 0, `bus_width_o` is 0, `launch_fall_o` is 0 and `latch_sel_o` is 0.
- R2: A configuration word sampled on rising edge N drives the outputs and the clock generator after rising edge N+2. It is not visible before that edge.
- R3: While running with divide field D (bits 7:0), every high half-period and every low half-period that is not stretched by gating lasts exactly D+1 host cycles. The period is therefore 2*(D+1).
- R4: With the enable bit (bit 8) at 0, the clock completes any high half-period already in progress. It then stays low for as long as the bit is 0.
- R5: With the power-save bit (bit 9) at 1, a high half-period starts only if `xfer_busy_i` was 1 at the deciding edge. With bit 9 at 0, `xfer_busy_i` has no effect on the clock.
- R6: With the flow bit (bit 12) at 1, a high half-period does not start while (`rd_xfer_i` and `rx_full_i`) or (`wr_xfer_i` and `tx_empty_i`) holds. With bit 12 at 0, these inputs have no effect on the clock.
- R7: Bits 11:10 decode to `bus_width_o`. The value 00 gives 0 (1-bit). The value 10 gives 1 (4-bit). The values 01 and 11 both give 2 (8-bit). The value 3 is never output.
- R8: `launch_fall_o` follows bit 13. `latch_sel_o` follows bits 15:14 unchanged, where 0 means falling edge, 1 rising edge, 2 feedback clock and 3 loopback clock.
- R9: A new divide value takes effect only at the start of a high half-period. The low half-period that follows a high half-period uses the same divide value as that high half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration word |
| xfer_busy_i | input | 1 | A command or data transfer is in progress |
| rd_xfer_i | input | 1 | A read transfer is in progress |
| wr_xfer_i | input | 1 | A write transfer is in progress |
| rx_full_i | input | 1 | Receive FIFO is full |
| tx_empty_i | input | 1 | Transmit FIFO is empty |
| card_clk_o | output | 1 | Card bus clock |
| bus_width_o | output | 2 | Decoded width: 0 is 1-bit, 1 is 4-bit, 2 is 8-bit |
| launch_fall_o | output | 1 | Outputs launch on the falling card-clock edge when set |
| latch_sel_o | output | 2 | Input latch source select, forwarded |

## Verification
A configuration word can become active at the very edge where a parked clock is released by its gating condition clearing. In that case the divide value used for the new period depends on which of the two events the sequencer sees first. The bench provokes this collision by writing a new divide value while the clock is parked in power-save. It then raises `xfer_busy_i` so that it is sampled on the same edge the word becomes active, and also one edge earlier. The reference model predicts the length of each high half-period, and every cycle of `card_clk_o` is compared against that prediction. A second collision lines up a flow-control stall release with the last cycle of a low half-period.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    localparam int CFG_W = 16;
    localparam int DIV_W = 8;

    // Field layout of the configuration word; positions are decoded by the data path.
    typedef struct packed {
        logic [1:0]       latch_sel;  // 15:14
        logic             launch_fall;// 13
        logic             flow_en;    // 12
        logic [1:0]       width_code; // 11:10
        logic             pwr_save;   // 9
        logic             clk_en;     // 8
        logic [DIV_W-1:0] div;        // 7:0
    } clk_cfg_t;

    typedef enum logic [1:0] {
        CK_LOW  = 2'd0,
        CK_HIGH = 2'd1,
        CK_PARK = 2'd2
    } ck_state_e;

    typedef enum logic [1:0] {
        BW_1 = 2'd0,
        BW_4 = 2'd1,
        BW_8 = 2'd2
    } bus_width_e;

endpackage

// File: rtl/cardclk_cfg_pipe.sv
module cardclk_cfg_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act
);
    localparam int NSTG = DEPTH - 1;

    logic [NSTG-1:0] vld;
    logic [W-1:0]    stg [NSTG];

    genvar g;
    generate
        for (g = 0; g < NSTG; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld[g] <= 1'b0;
                        stg[g] <= '0;
                    end else begin
                        vld[g] <= wr;
                        stg[g] <= wdata;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld[g] <= 1'b0;
                        stg[g] <= '0;
                    end else begin
                        vld[g] <= vld[g-1];
                        stg[g] <= stg[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= '0;
        end else if (vld[NSTG-1]) begin
            act <= stg[NSTG-1];
        end
    end

endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate
    import cardclk_pkg::*;
(
    input  clk_cfg_t cfg,
    input  logic     busy,
    input  logic     rd_xfer,
    input  logic     wr_xfer,
    input  logic     rx_full,
    input  logic     tx_empty,
    output logic     run_ok
);
    logic idle_block;
    logic flow_block;

    always_comb begin
        idle_block = cfg.pwr_save && !busy;
        flow_block = cfg.flow_en && ((rd_xfer && rx_full) || (wr_xfer && tx_empty));
        run_ok     = cfg.clk_en && !idle_block && !flow_block;
    end

endmodule

// File: rtl/cardclk_width_dec.sv
module cardclk_width_dec
    import cardclk_pkg::*;
(
    input  logic [1:0] code,
    output logic [1:0] width
);
    bus_width_e w;

    always_comb begin
        unique case (code)
            2'b00:        w = BW_1;
            2'b10:        w = BW_4;
            2'b01, 2'b11: w = BW_8;
            default:      w = BW_1;
        endcase
        width = w;
    end

endmodule

// File: rtl/cardclk_fsm.sv
module cardclk_fsm
    import cardclk_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_ok,
    input  logic [DW-1:0] div_in,
    output logic          card_clk
);
    ck_state_e     st, st_nx;
    logic [DW-1:0] cnt, cnt_nx;
    logic [DW-1:0] div_q, div_nx;
    logic          half_end;

    assign half_end = (cnt == div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= CK_LOW;
            cnt   <= '0;
            div_q <= '0;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            div_q <= div_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        div_nx = div_q;
        unique case (st)
            CK_HIGH: begin
                if (half_end) begin            // hi_done
                    st_nx  = CK_LOW;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            CK_LOW: begin
                if (!half_end) begin
                    cnt_nx = cnt + 1'b1;
                end else if (run_ok) begin     // lo_go
                    st_nx  = CK_HIGH;
                    cnt_nx = '0;
                    div_nx = div_in;
                end else begin                 // lo_stall
                    st_nx  = CK_PARK;
                end
            end
            CK_PARK: begin
                if (run_ok) begin              // park_go
                    st_nx  = CK_HIGH;
                    cnt_nx = '0;
                    div_nx = div_in;
                end
            end
            default: begin
                st_nx  = CK_LOW;
                cnt_nx = '0;
            end
        endcase
    end

    always_comb begin
        card_clk = (st == CK_HIGH);
    end

endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
    import cardclk_pkg::*;
#(
    parameter int CFG_DELAY = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             xfer_busy_i,
    input  logic             rd_xfer_i,
    input  logic             wr_xfer_i,
    input  logic             rx_full_i,
    input  logic             tx_empty_i,
    output logic             card_clk_o,
    output logic [1:0]       bus_width_o,
    output logic             launch_fall_o,
    output logic [1:0]       latch_sel_o
);
    logic [CFG_W-1:0] act_cfg;
    clk_cfg_t         cfg;
    logic             run_ok;

    cardclk_cfg_pipe #(.W(CFG_W), .DEPTH(CFG_DELAY)) u_pipe (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .wr    (cfg_wr_i),
        .wdata (cfg_wdata_i),
        .act   (act_cfg)
    );

    assign cfg = clk_cfg_t'(act_cfg);

    cardclk_gate u_gate (
        .cfg      (cfg),
        .busy     (xfer_busy_i),
        .rd_xfer  (rd_xfer_i),
        .wr_xfer  (wr_xfer_i),
        .rx_full  (rx_full_i),
        .tx_empty (tx_empty_i),
        .run_ok   (run_ok)
    );

    cardclk_fsm #(.DW(DIV_W)) u_fsm (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .run_ok   (run_ok),
        .div_in   (cfg.div),
        .card_clk (card_clk_o)
    );

    cardclk_width_dec u_wdec (
        .code  (cfg.width_code),
        .width (bus_width_o)
    );

    assign launch_fall_o = cfg.launch_fall;
    assign latch_sel_o   = cfg.latch_sel;

endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        card_clk,
    input logic [15:0] cfg_act,
    input logic        cfg_wr,
    input logic [15:0] cfg_wdata,
    input logic        busy,
    input logic        rd_xfer,
    input logic        wr_xfer,
    input logic        rx_full,
    input logic        tx_empty,
    input logic [1:0]  bus_width
);
    logic [7:0] prev_div;
    logic       prev_clk;
    logic [7:0] cap_div;
    logic [8:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_div <= '0;
            prev_clk <= 1'b0;
            cap_div  <= '0;
            hi_cnt   <= '0;
        end else begin
            prev_div <= cfg_act[7:0];
            prev_clk <= card_clk;
            if (card_clk && !prev_clk) begin
                cap_div <= prev_div;
                hi_cnt  <= 9'd1;
            end else if (card_clk) begin
                hi_cnt  <= hi_cnt + 9'd1;
            end
        end
    end

    // R2: word sampled three edges back is the active word now (delay of 3 fixed by default)
    p_cfg_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_wr, 3) && $past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3))
        |-> (cfg_act == $past(cfg_wdata, 3)));

    p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk) |-> (hi_cnt == ({1'b0, cap_div} + 9'd1)));

    p_stay_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_act[8] && !card_clk) |=> !card_clk);

    p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(!cfg_act[9] || busy));

    p_flow_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(!(cfg_act[12] && ((rd_xfer && rx_full) || (wr_xfer && tx_empty)))));

    p_width_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_width != 2'd3);

endmodule

bind cardclk_ctrl cardclk_chk u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .card_clk  (card_clk_o),
    .cfg_act   (act_cfg),
    .cfg_wr    (cfg_wr_i),
    .cfg_wdata (cfg_wdata_i),
    .busy      (xfer_busy_i),
    .rd_xfer   (rd_xfer_i),
    .wr_xfer   (wr_xfer_i),
    .rx_full   (rx_full_i),
    .tx_empty  (tx_empty_i),
    .bus_width (bus_width_o)
);

// File: tb/sim_cardclk_ctrl.sv
module sim_cardclk_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic        xfer_busy_i = 1'b0;
    logic        rd_xfer_i = 1'b0;
    logic        wr_xfer_i = 1'b0;
    logic        rx_full_i = 1'b0;
    logic        tx_empty_i = 1'b0;
    logic        card_clk_o;
    logic [1:0]  bus_width_o;
    logic        launch_fall_o;
    logic [1:0]  latch_sel_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cardclk_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .xfer_busy_i(xfer_busy_i), .rd_xfer_i(rd_xfer_i), .wr_xfer_i(wr_xfer_i),
        .rx_full_i(rx_full_i), .tx_empty_i(tx_empty_i), .card_clk_o(card_clk_o),
        .bus_width_o(bus_width_o), .launch_fall_o(launch_fall_o), .latch_sel_o(latch_sel_o)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int rises = 0;
    bit done = 0;
    string cur_req = "R3";

    // behavioural reference
    bit          m_hi, m_park, m_run;
    int          m_cnt, m_len;
    logic [15:0] m_act;
    logic [15:0] q_data[$];
    int          q_due[$];

    function automatic int exp_width(logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b10) return 1;
        return 2;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_ni) begin
            m_hi = 0; m_park = 0; m_cnt = 0; m_len = 1; m_act = '0;
            q_data.delete(); q_due.delete();
        end else begin
            m_run = m_act[8] && (!m_act[9] || xfer_busy_i) &&
                    !(m_act[12] && ((rd_xfer_i && rx_full_i) || (wr_xfer_i && tx_empty_i)));
            if (m_hi) begin
                m_cnt++;
                if (m_cnt == m_len) begin m_hi = 0; m_cnt = 0; end
            end else if (m_park || m_cnt + 1 >= m_len) begin
                if (m_run) begin
                    m_hi = 1; m_park = 0; m_cnt = 0; m_len = int'(m_act[7:0]) + 1;
                end else begin
                    m_park = 1;
                end
            end else begin
                m_cnt++;
            end
            for (int i = 0; i < q_due.size(); i++) q_due[i]--;
            while (q_due.size() > 0 && q_due[0] == 0) begin
                m_act = q_data[0];
                void'(q_data.pop_front());
                void'(q_due.pop_front());
            end
            if (cfg_wr_i) begin
                q_data.push_back(cfg_wdata_i);
                q_due.push_back(2);
            end
        end
    end

    logic prev_clk = 1'b0;
    always @(negedge clk) begin
        if (rst_ni && !done) begin
            check(cur_req, "card_clk", int'(card_clk_o), int'(m_hi));
            check("R7", "bus_width", int'(bus_width_o), exp_width(m_act[11:10]));
            check("R8", "launch", int'(launch_fall_o), int'(m_act[13]));
            check("R8", "latch_sel", int'(latch_sel_o), int'(m_act[15:14]));
            if (card_clk_o && !prev_clk) rises++;
            prev_clk = card_clk_o;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(logic [15:0] w);
        @(negedge clk);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = w;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset card_clk", int'(card_clk_o), 0);
        check("R1", "reset width", int'(bus_width_o), 0);
        check("R1", "reset launch", int'(launch_fall_o), 0);
        check("R1", "reset latch", int'(latch_sel_o), 0);

        // R2 three-edge delay of a new word
        cur_req = "R2";
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_wdata_i = 16'hC100;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        check("R2", "latch one edge after", int'(latch_sel_o), 0);
        @(negedge clk);
        check("R2", "latch two edges after", int'(latch_sel_o), 0);
        @(negedge clk);
        check("R2", "latch three edges after", int'(latch_sel_o), 3);

        // R3 free running, div 0 then div 3
        cur_req = "R3";
        tick(12);
        write_cfg(16'h0103);
        tick(40);
        // R9 divider change in the middle of a period
        cur_req = "R9";
        tick(3);
        write_cfg(16'h0101);
        tick(30);
        write_cfg(16'h0105);
        tick(2);
        write_cfg(16'h0100);
        tick(40);

        // R4 enable off mid-run, clock must stay low
        cur_req = "R4";
        write_cfg(16'h0003);
        tick(12);
        rises = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R4", "stays low", int'(card_clk_o), 0);
        end
        check("R4", "no rise while off", rises, 0);

        // R5 power save
        cur_req = "R5";
        write_cfg(16'h0301);
        tick(10);
        rises = 0;
        tick(20);
        check("R5", "no rise while idle", rises, 0);
        xfer_busy_i = 1'b1;
        tick(20);
        xfer_busy_i = 1'b0;
        tick(7);
        xfer_busy_i = 1'b1;
        tick(3);
        xfer_busy_i = 1'b0;
        tick(10);
        // collision: new divider becomes active on the edge busy is first seen
        write_cfg(16'h0302);   // sampled edge N, strobe dropped after N
        tick(1);               // negedge after N+1
        xfer_busy_i = 1'b1;    // sampled at N+2 together with activation
        tick(20);
        xfer_busy_i = 1'b0;
        tick(8);
        write_cfg(16'h0304);
        xfer_busy_i = 1'b1;    // sampled one edge before activation
        tick(30);
        xfer_busy_i = 1'b0;
        // power save off: busy ignored
        write_cfg(16'h0101);
        tick(6);
        rises = 0;
        tick(24);
        check("R5", "runs with busy low when save off", rises, 6);

        // R6 flow control
        cur_req = "R6";
        write_cfg(16'h1101);
        rd_xfer_i = 1'b1; rx_full_i = 1'b1;
        tick(8);
        rises = 0;
        tick(30);
        check("R6", "held on rx full", rises, 0);
        rx_full_i = 1'b0;
        tick(13);
        rx_full_i = 1'b1; tick(1); rx_full_i = 1'b0;
        tick(10);
        rd_xfer_i = 1'b0;
        wr_xfer_i = 1'b1; tx_empty_i = 1'b1;
        tick(8);
        rises = 0;
        tick(20);
        check("R6", "held on tx empty", rises, 0);
        tx_empty_i = 1'b0;
        tick(15);
        tx_empty_i = 1'b1;
        rx_full_i = 1'b1;
        write_cfg(16'h0101);
        tick(6);
        rises = 0;
        tick(24);
        check("R6", "flow off ignores fifo", rises, 6);
        wr_xfer_i = 1'b0; tx_empty_i = 1'b0; rx_full_i = 1'b0;

        // R7 and R8 field decode
        cur_req = "R7";
        write_cfg(16'h0900);
        tick(3);
        check("R7", "width 10 gives 4-bit", int'(bus_width_o), 1);
        write_cfg(16'h0500);
        tick(3);
        check("R7", "width 01 gives 8-bit", int'(bus_width_o), 2);
        write_cfg(16'h2D00);
        tick(3);
        check("R7", "width 11 gives 8-bit", int'(bus_width_o), 2);
        check("R8", "launch bit set", int'(launch_fall_o), 1);
        write_cfg(16'h4100);
        tick(3);
        check("R7", "width 00 gives 1-bit", int'(bus_width_o), 0);
        check("R8", "latch select 1", int'(latch_sel_o), 1);
        check("R8", "launch bit clear", int'(launch_fall_o), 0);
        write_cfg(16'h8100);
        tick(3);
        check("R8", "latch select 2", int'(latch_sel_o), 2);
        tick(10);

        finish_run();
    end

endmodule